// File: doc/BRIEF.md
# Serial Configuration Chain with Latch Routing

This block is the serial write path of a multi-channel LED PWM controller. A single shift chain takes one bit from the serial input on every rising edge of the serial clock. The top bit of the chain drives the serial output, so several controllers can be daisy-chained. A rising edge on the latch strobe routes the chain contents to one of two places. If the top bit is clear, the chain's lower bits go to a per-channel grayscale latch. If the top bit is set and a guard byte matches, the chain's lower bits go to a control latch. The control latch holds per-output dot-correction codes, per-colour brightness and current-range fields, and five mode flags.

After a grayscale write, the block can copy per-output fault flags (open LED and shorted LED) from input vectors back into the upper part of the chain. A host then reads them by shifting. The effective current-range setting is protected against corrupted writes: it changes only when the same value arrives in two control writes in a row. The dot-correction codes reach the working output register only when the timing controller pulses a load strobe. The whole block runs on one system clock. The serial clock and latch strobe are synchronous inputs, and the block acts on their sampled edges.

Top module: `cfg_chain_router`

## Requirements
- R1: On each sampled rising edge of `sclk`, the chain moves one place toward its top bit and takes `sin` into bit 0. `sout` always shows the top bit, so a word shifted in top-bit-first reads back unchanged.
- R2: On a sampled rising edge of `lat` with the chain's top bit at 0, `gs_data` takes chain bits [48N-1:0]. Here N = NUM_CH. Output n, colour c (R=0, G=1, B=2) owns bits [48n+16c+15 : 48n+16c]. The control outputs do not change.
- R3: On a sampled rising edge of `lat` with the top bit at 1 and chain bits [48N-1:48N-8] equal to 8'h96, the control latch loads. Chain bits [21N-1:0] are the pending dot-correction codes (7 bits per output, in grayscale order). The next 9 bits are the current-range field. The next 21 bits go to `bc_data`. The next 5 bits go to `fn_flags`. `gs_data` does not change.
- R4: A latch edge with the top bit at 1 and any other guard byte changes no output.
- R5: `mc_data` resets to 0. It takes a new value only on a control write whose current-range field equals the field of the previous accepted control write.
- R6: `dc_data` changes only on a cycle with `dc_load` high. It then copies the pending dot-correction codes from the last control write.
- R7: When a grayscale write happens while `fn_flags[2]` (auto refresh) is 0, the falling edge of `lat` that follows loads fault flags into the chain. `lod_flags[k]` goes to chain bit 48N-3N+k and `lsd_flags[k]` goes to chain bit 48N-6N+k, where k = 3n+c. All other chain bits keep their values.
- R8: No fault flags are loaded after a control write, and none are loaded after a grayscale write made while `fn_flags[2]` is 1.
- R9: After a fault-flag load, a further load cannot happen until at least one bit has been shifted in.
- R10: After synchronous reset, every latch, the chain and `sout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial shift clock, sampled |
| lat | input | 1 | Latch strobe, sampled |
| sin | input | 1 | Serial data in |
| sout | output | 1 | Top bit of the chain |
| lod_flags | input | 3*NUM_CH | Open-LED fault flags, index 3n+c |
| lsd_flags | input | 3*NUM_CH | Shorted-LED fault flags, index 3n+c |
| dc_load | input | 1 | Strobe from the timing controller that moves pending dot-correction codes into `dc_data` |
| gs_data | output | 48*NUM_CH | Grayscale latch |
| dc_data | output | 21*NUM_CH | Working dot-correction register |
| mc_data | output | 9 | Effective current-range fields for R, G, B (3 bits each) |
| bc_data | output | 21 | Brightness fields for R, G, B (7 bits each) |
| fn_flags | output | 5 | Mode flags; bit 2 is auto refresh |

## Verification
The hardest state to reach from the ports is the disarmed status path. A fault load must have just happened, no bit may have been shifted since, and the flag inputs must have changed. Only then does a second latch pulse show whether the block wrongly loads again. The stimulus gets there by issuing a grayscale write, pulsing the latch a second time without any shift, and changing the flag vectors in between. It then reads the whole chain back out and compares it against the first flag set. The rule that the current range needs two matching writes is reached by a vector table in which matching and differing control writes are interleaved with grayscale writes and with a write that carries a bad guard byte.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;
  localparam int COLORS   = 3;
  localparam int GS_BITS  = 16;
  localparam int DC_BITS  = 7;
  localparam int MC_BITS  = 3;
  localparam int BC_BITS  = 7;
  localparam int FN_BITS  = 5;
  localparam int KEY_BITS = 8;
  localparam logic [KEY_BITS-1:0] CTRL_KEY = 8'h96;

  // mode flag positions inside fn_flags
  localparam int FN_REPEAT  = 0;
  localparam int FN_TMRST   = 1;
  localparam int FN_REFRESH = 2;
  localparam int FN_SPREAD  = 3;
  localparam int FN_SHORTHI = 4;

  // flat index of output (channel, colour)
  function automatic int flag_idx(input int ch, input int col);
    return ch * COLORS + col;
  endfunction

  function automatic logic key_ok(input logic [KEY_BITS-1:0] k);
    return k == CTRL_KEY;
  endfunction
endpackage

// File: rtl/cfg_chain_shifter.sv
module cfg_chain_shifter
  import cfg_chain_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int FLAG_N = COLORS * NUM_CH,
  localparam int GS_W   = FLAG_N * GS_BITS,
  localparam int SR_W   = GS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sin_i,
  input  logic              sid_load,
  input  logic [FLAG_N-1:0] lod_i,
  input  logic [FLAG_N-1:0] lsd_i,
  output logic [SR_W-1:0]   sr_q,
  output logic              armed_q
);
  localparam int LOD_LO = GS_W - FLAG_N;
  localparam int LSD_LO = GS_W - 2 * FLAG_N;

  logic [SR_W-1:0] merged;

  always_comb begin
    merged = sr_q;
    for (int n = 0; n < NUM_CH; n++) begin
      for (int c = 0; c < COLORS; c++) begin
        merged[LOD_LO + flag_idx(n, c)] = lod_i[flag_idx(n, c)];
        merged[LSD_LO + flag_idx(n, c)] = lsd_i[flag_idx(n, c)];
      end
    end
  end

  // a status load wins over a shift in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q    <= '0;
      armed_q <= 1'b1;
    end else if (sid_load) begin
      sr_q    <= merged;
      armed_q <= 1'b0;
    end else if (shift_en) begin
      sr_q    <= {sr_q[SR_W-2:0], sin_i};
      armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_chain_decode.sv
module cfg_chain_decode
  import cfg_chain_pkg::*;
(
  input  logic                lat_rise,
  input  logic                top_bit,
  input  logic [KEY_BITS-1:0] key,
  output logic                gs_wr,
  output logic                ctrl_wr
);
  assign gs_wr   = lat_rise & ~top_bit;
  assign ctrl_wr = lat_rise & top_bit & key_ok(key);
endmodule

// File: rtl/cfg_chain_mc_guard.sv
module cfg_chain_mc_guard #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] mc_in,
  output logic [W-1:0] mc_out
);
  logic [W-1:0] pend_q;
  logic         pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_out <= '0;
      pend_q <= '0;
      pend_v <= 1'b0;
    end else if (wr) begin
      if (pend_v && (mc_in == pend_q)) mc_out <= mc_in;
      pend_q <= mc_in;
      pend_v <= 1'b1;
    end
  end
endmodule

// File: rtl/cfg_chain_router.sv
module cfg_chain_router
  import cfg_chain_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               sclk,
  input  logic                               lat,
  input  logic                               sin,
  output logic                               sout,
  input  logic [COLORS*NUM_CH-1:0]           lod_flags,
  input  logic [COLORS*NUM_CH-1:0]           lsd_flags,
  input  logic                               dc_load,
  output logic [COLORS*NUM_CH*GS_BITS-1:0]   gs_data,
  output logic [COLORS*NUM_CH*DC_BITS-1:0]   dc_data,
  output logic [COLORS*MC_BITS-1:0]          mc_data,
  output logic [COLORS*BC_BITS-1:0]          bc_data,
  output logic [FN_BITS-1:0]                 fn_flags
);
  localparam int FLAG_N = COLORS * NUM_CH;
  localparam int GS_W   = FLAG_N * GS_BITS;
  localparam int SR_W   = GS_W + 1;
  localparam int DC_W   = FLAG_N * DC_BITS;
  localparam int MC_W   = COLORS * MC_BITS;
  localparam int BC_W   = COLORS * BC_BITS;
  localparam int MC_LO  = DC_W;
  localparam int BC_LO  = MC_LO + MC_W;
  localparam int FN_LO  = BC_LO + BC_W;
  localparam int KEY_LO = GS_W - KEY_BITS;

  logic            sclk_q, lat_q;
  logic            shift_fire, lat_rise, lat_fall;
  logic            gs_fire, ctrl_fire, sid_fire;
  logic            sid_pend, sid_armed;
  logic [SR_W-1:0] sr_q;
  logic [DC_W-1:0] dc_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      sclk_q <= sclk;
      lat_q  <= lat;
    end
  end

  assign shift_fire = sclk & ~sclk_q;
  assign lat_rise   = lat & ~lat_q;
  assign lat_fall   = ~lat & lat_q;
  assign sid_fire   = lat_fall & sid_pend & sid_armed;

  cfg_chain_shifter #(.NUM_CH(NUM_CH)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_fire),
    .sin_i    (sin),
    .sid_load (sid_fire),
    .lod_i    (lod_flags),
    .lsd_i    (lsd_flags),
    .sr_q     (sr_q),
    .armed_q  (sid_armed)
  );

  cfg_chain_decode u_dec (
    .lat_rise (lat_rise),
    .top_bit  (sr_q[SR_W-1]),
    .key      (sr_q[KEY_LO +: KEY_BITS]),
    .gs_wr    (gs_fire),
    .ctrl_wr  (ctrl_fire)
  );

  cfg_chain_mc_guard #(.W(MC_W)) u_mc (
    .clk    (clk),
    .rst    (rst),
    .wr     (ctrl_fire),
    .mc_in  (sr_q[MC_LO +: MC_W]),
    .mc_out (mc_data)
  );

  // status request: armed by a grayscale write without auto refresh
  always_ff @(posedge clk) begin
    if (rst) sid_pend <= 1'b0;
    else if (gs_fire) sid_pend <= ~fn_flags[FN_REFRESH];
    else if (ctrl_fire || lat_fall) sid_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gs_data  <= '0;
      dc_pend  <= '0;
      bc_data  <= '0;
      fn_flags <= '0;
      dc_data  <= '0;
    end else begin
      if (gs_fire) gs_data <= sr_q[GS_W-1:0];
      if (ctrl_fire) begin
        dc_pend  <= sr_q[DC_W-1:0];
        bc_data  <= sr_q[BC_LO +: BC_W];
        fn_flags <= sr_q[FN_LO +: FN_BITS];
      end
      if (dc_load) dc_data <= dc_pend;
    end
  end

  assign sout = sr_q[SR_W-1];
endmodule

// File: rtl/cfg_chain_checker.sv
module cfg_chain_checker #(
  parameter int SR_W   = 769,
  parameter int GS_W   = 768,
  parameter int DC_W   = 336,
  parameter int KEY_LO = 760
) (
  input logic            clk,
  input logic            rst,
  input logic            sin,
  input logic            shift_fire,
  input logic            lat_rise,
  input logic            gs_fire,
  input logic            ctrl_fire,
  input logic            sid_fire,
  input logic            sid_armed,
  input logic            dc_load,
  input logic [SR_W-1:0] sr_q,
  input logic [GS_W-1:0] gs_data,
  input logic [DC_W-1:0] dc_data,
  input logic [8:0]      mc_data,
  input logic [20:0]     bc_data,
  input logic [4:0]      fn_flags
);
  a_r1_shift_step: assert property (@(posedge clk) disable iff (rst)
    (shift_fire && !sid_fire) |=> (sr_q == {$past(sr_q[SR_W-2:0]), $past(sin)}));

  a_r2_gs_copy: assert property (@(posedge clk) disable iff (rst)
    gs_fire |=> (gs_data == $past(sr_q[GS_W-1:0])));

  a_r2_gs_quiet: assert property (@(posedge clk) disable iff (rst)
    !gs_fire |=> $stable(gs_data));

  a_r4_bad_key_holds: assert property (@(posedge clk) disable iff (rst)
    (lat_rise && sr_q[SR_W-1] && (sr_q[KEY_LO +: 8] != 8'h96)) |=>
      ($stable(bc_data) && $stable(fn_flags) && $stable(mc_data) && $stable(gs_data)));

  a_r5_mc_only_on_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(mc_data) |-> $past(ctrl_fire));

  a_r6_dc_hold: assert property (@(posedge clk) disable iff (rst)
    !dc_load |=> $stable(dc_data));

  a_r8_no_sid_after_ctrl: assert property (@(posedge clk) disable iff (rst)
    ctrl_fire |=> !sid_fire);

  a_r9_disarm: assert property (@(posedge clk) disable iff (rst)
    sid_fire |=> !sid_armed);

  a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
    (!sid_armed && !shift_fire) |=> !sid_fire);
endmodule

bind cfg_chain_router cfg_chain_checker #(
  .SR_W(SR_W), .GS_W(GS_W), .DC_W(DC_W), .KEY_LO(KEY_LO)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sin        (sin),
  .shift_fire (shift_fire),
  .lat_rise   (lat_rise),
  .gs_fire    (gs_fire),
  .ctrl_fire  (ctrl_fire),
  .sid_fire   (sid_fire),
  .sid_armed  (sid_armed),
  .dc_load    (dc_load),
  .sr_q       (sr_q),
  .gs_data    (gs_data),
  .dc_data    (dc_data),
  .mc_data    (mc_data),
  .bc_data    (bc_data),
  .fn_flags   (fn_flags)
);

// File: tb/cfg_chain_router_test.sv
module cfg_chain_router_test;
  localparam int NCH    = 4;
  localparam int FLAGS  = 3 * NCH;
  localparam int GS_W   = 48 * NCH;
  localparam int SR_W   = GS_W + 1;
  localparam int DC_W   = 21 * NCH;
  localparam int MC_LO  = DC_W;
  localparam int BC_LO  = MC_LO + 9;
  localparam int FN_LO  = BC_LO + 21;
  localparam int KEY_LO = GS_W - 8;

  // {kind[1:0], seed[31:0], mc[8:0], fn[4:0]}; kind 0 = grayscale, 1 = control, 2 = bad key
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {2'd1, 32'h1234_5678, 9'h1A3, 5'b11001},
    {2'd0, 32'hCAFE_0001, 9'h000, 5'b00000},
    {2'd1, 32'h0BAD_F00D, 9'h1A3, 5'b01010},
    {2'd2, 32'h7777_1111, 9'h055, 5'b11111},
    {2'd1, 32'h2468_ACE1, 9'h055, 5'b10011},
    {2'd1, 32'h1357_9BDF, 9'h0F0, 5'b00001},
    {2'd1, 32'h5A5A_3C3C, 9'h0F0, 5'b10010},
    {2'd0, 32'hDEAD_BEEF, 9'h000, 5'b00000}
  };

  logic clk = 1'b0;
  logic rst, sclk, lat, sin, dc_load, sout;
  logic [FLAGS-1:0] lod_flags, lsd_flags;
  logic [GS_W-1:0]  gs_data;
  logic [DC_W-1:0]  dc_data;
  logic [8:0]       mc_data;
  logic [20:0]      bc_data;
  logic [4:0]       fn_flags;

  always #2.5 clk = ~clk;

  cfg_chain_router #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst(rst), .sclk(sclk), .lat(lat), .sin(sin), .sout(sout),
    .lod_flags(lod_flags), .lsd_flags(lsd_flags), .dc_load(dc_load),
    .gs_data(gs_data), .dc_data(dc_data), .mc_data(mc_data),
    .bc_data(bc_data), .fn_flags(fn_flags)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [SR_W-1:0] v, rd, e;
  logic [GS_W-1:0] exp_gs;
  logic [DC_W-1:0] exp_dc;
  logic [8:0]      exp_mc, mc_prev;
  bit              mc_prev_v;
  logic [20:0]     exp_bc;
  logic [4:0]      exp_fn;

  task automatic chk(input string req, input string what,
                     input logic [SR_W-1:0] act, input logic [SR_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [SR_W-1:0] mk(input bit top, input bit good, input logic [31:0] seed,
                                         input logic [8:0] mc, input logic [4:0] fn);
    logic [31:0] s;
    logic [SR_W-1:0] r;
    s = seed;
    for (int i = 0; i < SR_W; i++) begin
      s = s ^ (s << 13);
      s = s ^ (s >> 17);
      s = s ^ (s << 5);
      r[i] = s[3];
    end
    r[SR_W-1] = top;
    if (top) begin
      r[KEY_LO +: 8] = good ? 8'h96 : 8'h69;
      r[MC_LO +: 9]  = mc;
      r[FN_LO +: 5]  = fn;
    end
    return r;
  endfunction

  // chain image after a status load, per R7
  function automatic logic [SR_W-1:0] with_status(input logic [SR_W-1:0] base,
                                                  input logic [FLAGS-1:0] od, input logic [FLAGS-1:0] sd);
    logic [SR_W-1:0] r;
    r = base;
    for (int n = 0; n < NCH; n++)
      for (int c = 0; c < 3; c++) begin
        r[GS_W - FLAGS + 3*n + c]   = od[3*n + c];
        r[GS_W - 2*FLAGS + 3*n + c] = sd[3*n + c];
      end
    return r;
  endfunction

  task automatic shift_bit(input logic b);
    @(negedge clk); sin = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic shift_word(input logic [SR_W-1:0] w);
    for (int i = SR_W - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic read_all(output logic [SR_W-1:0] r);
    for (int i = 0; i < SR_W; i++) begin
      r[SR_W-1-i] = sout;
      shift_bit(1'b0);
    end
  endtask

  task automatic pulse_lat();
    @(negedge clk); lat = 1'b1;
    @(negedge clk); lat = 1'b0;
    @(negedge clk);
  endtask

  task automatic model_ctrl(input logic [SR_W-1:0] w);
    exp_dc = w[DC_W-1:0];
    exp_bc = w[BC_LO +: 21];
    exp_fn = w[FN_LO +: 5];
    if (mc_prev_v && (w[MC_LO +: 9] == mc_prev)) exp_mc = w[MC_LO +: 9];
    mc_prev   = w[MC_LO +: 9];
    mc_prev_v = 1'b1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    rst = 1'b1; sclk = 1'b0; lat = 1'b0; sin = 1'b0; dc_load = 1'b0;
    lod_flags = '0; lsd_flags = '0;
    exp_gs = '0; exp_dc = '0; exp_mc = '0; mc_prev = '0; mc_prev_v = 1'b0;
    exp_bc = '0; exp_fn = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10: reset state
    chk("R10", "gs_data", gs_data, '0);
    chk("R10", "mc_data", mc_data, '0);
    chk("R10", "bc/fn", {bc_data, fn_flags}, '0);
    chk("R10", "dc_data", dc_data, '0);
    chk("R10", "sout", sout, '0);

    // R1: shift-through readback
    v = mk(1'b0, 1'b0, 32'h0F1E_2D3C, 9'h0, 5'h0);
    shift_word(v);
    read_all(rd);
    chk("R1", "readback", rd, v);

    // vector table: R2 R3 R4 R5
    for (int t = 0; t < NV; t++) begin
      logic [1:0] kind;
      kind = VEC[t][47:46];
      v = mk(kind != 2'd0, kind == 2'd1, VEC[t][45:14], VEC[t][13:5], VEC[t][4:0]);
      shift_word(v);
      pulse_lat();
      if (kind == 2'd0) exp_gs = v[GS_W-1:0];
      if (kind == 2'd1) model_ctrl(v);
      chk(kind == 2'd0 ? "R2" : (kind == 2'd1 ? "R3" : "R4"), "gs_data", gs_data, exp_gs);
      chk(kind == 2'd2 ? "R4" : "R3", "bc_data", bc_data, exp_bc);
      chk(kind == 2'd2 ? "R4" : "R3", "fn_flags", fn_flags, exp_fn);
      chk("R5", "mc_data", mc_data, exp_mc);
    end

    // R6: no strobe, no change; strobe copies pending codes
    chk("R6", "dc before strobe", dc_data, '0);
    @(negedge clk); dc_load = 1'b1;
    @(negedge clk); dc_load = 1'b0;
    chk("R6", "dc after strobe", dc_data, exp_dc);

    // R7: status load after grayscale write with auto refresh off
    lod_flags = 12'hA5C; lsd_flags = 12'h3C9;
    v = mk(1'b0, 1'b0, 32'h3141_5926, 9'h0, 5'h0);
    shift_word(v);
    pulse_lat();
    read_all(rd);
    chk("R7", "status image", rd, with_status(v, 12'hA5C, 12'h3C9));

    // R9: second latch without a shift must not reload status
    v = mk(1'b0, 1'b0, 32'h2718_2818, 9'h0, 5'h0);
    shift_word(v);
    pulse_lat();
    e = with_status(v, lod_flags, lsd_flags);
    lod_flags = 12'h5A3; lsd_flags = 12'hC36;
    pulse_lat();
    chk("R9", "gs from loaded chain", gs_data, e[GS_W-1:0]);
    read_all(rd);
    chk("R9", "no reload", rd, e);

    // R8: control write loads no status
    v = mk(1'b1, 1'b1, 32'h1618_0339, 9'h0F0, 5'b01001);
    shift_word(v);
    pulse_lat();
    model_ctrl(v);
    read_all(rd);
    chk("R8", "after control write", rd, v);
    chk("R5", "mc repeat", mc_data, exp_mc);

    // R8: auto refresh on suppresses the falling-edge load
    v = mk(1'b1, 1'b1, 32'h4142_1356, 9'h0F0, 5'b00100);
    shift_word(v);
    pulse_lat();
    model_ctrl(v);
    chk("R3", "refresh flag", fn_flags, exp_fn);
    v = mk(1'b0, 1'b0, 32'h1732_0508, 9'h0, 5'h0);
    shift_word(v);
    pulse_lat();
    chk("R2", "gs with refresh", gs_data, v[GS_W-1:0]);
    read_all(rd);
    chk("R8", "refresh on", rd, v);

    done = 1;
    summary();
  end
endmodule